// File: doc/BRIEF.md
# Key-Triggered Voice Message Controller

This block is the control sequencer of a single-channel voice recorder that stores audio in an external sample memory. After the standby input is released it fixes how many equal slots the memory is split into (one, two, four or eight). From then on each of up to eight active-low push keys owns one slot. A record/play switch chooses what a key press does. In record position, holding a key writes samples into that key's slot, one write strobe per sample tick. In play position, one press starts reading back what was stored, and the next press of the same key stops it.

The controller filters every key against contact bounce. It computes slot addresses arithmetically from the slot index and the latched mode. It keeps a directory with the recorded length of each slot and the mode in which that slot was written. Audible cues are requested from a separate tone generator as single or double beep pulses. An active-low busy flag tells the outside world when a recording or playback is in progress. The analog path, the audio output and the tone waveform are not part of this block.

Top module: `voice_msg_ctrl`

## Requirements
- R1: While `rst_n` is low the mode is taken from `msel`, and it is held unchanged while `rst_n` stays high. The slot count is 2 to the power of the value of `msel`, so 3 gives 8 slots, 2 gives 4, 1 gives 2 and 0 gives 1. A floating pin reads as 1.
- R2: With N slots and an address width A, slot k covers the addresses k·2^A/N up to (k+1)·2^A/N−1. Keys with an index of N or more have no effect.
- R3: With `rec_n` low, an accepted press of a valid key pulses `beep_once` for one cycle and starts a recording into that key's slot. Each `tick` during the recording gives one `mem_wr` pulse in the next cycle, at consecutive addresses starting from the slot base.
- R4: A recording ends when the key's release is accepted or right after the slot's last address has been written, whichever comes first. `beep_twice` then pulses for one cycle.
- R5: A new recording replaces the slot's previous length. A recording cut short by standby leaves the slot empty.
- R6: With `rec_n` high, an accepted press of a valid key whose slot holds a message starts playback. Each `tick` gives one `mem_rd` pulse in the next cycle, at consecutive addresses starting from the slot base.
- R7: Playback ends once the recorded number of samples has been read, or on the next accepted press of the same key.
- R8: `busy_n` is low exactly while a recording or playback is in progress, and high when idle, in standby and after power-up.
- R9: While `rst_n` is low, all strobes stop, `busy_n` is high and key presses are ignored. When `rst_n` goes high, `beep_once` pulses once in the following cycle and the block becomes idle.
- R10: A key level counts as changed only after it has differed from the accepted level for `DEB_CYC` consecutive clock cycles (after a two-stage input synchroniser).
- R11: On wake-up, every slot recorded under a mode other than the latched one is discarded. A press on such a slot in play position does nothing, even if the earlier mode is later selected again.
- R12: A press in play position on an empty slot starts nothing: no `mem_rd`, and `busy_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up clear, active low. Clears the slot directory once. |
| rst_n | input | 1 | Standby when low. Wake-up on the rising edge. |
| msel | input | 2 | Mode select, value = log2 of the slot count |
| rec_n | input | 1 | Low selects record, high selects play |
| key_n | input | 8 | Message keys, active low, raw from the switches |
| tick | input | 1 | Sample tick, one cycle per sample |
| mem_addr | output | ADDR_W | Sample memory address for the current strobe |
| mem_wr | output | 1 | Write strobe for one sample |
| mem_rd | output | 1 | Read strobe for one sample |
| beep_once | output | 1 | One-cycle request for a single beep |
| beep_twice | output | 1 | One-cycle request for a double beep |
| busy_n | output | 1 | Low while recording or playing |

## Verification
On every cycle the assertions check the following. Every strobe address lies inside the slot that is currently open. Writes only follow a recording cycle and reads only follow a playback cycle. The mode stays frozen while out of standby. Standby silences the strobes and busy flag, and a wake-up always yields exactly one single-beep pulse. What those properties cannot show needs the bench's scenarios: that recordings end on release or when the slot is full, that playback stops at the stored length or on a second press, that a re-recording replaces the old length, that a bounce shorter than the filter window is rejected, and that slots from another mode are dropped. The bench sweeps all four modes across all eight keys and compares counts and addresses against arithmetic of its own.

// File: rtl/vm_pkg.sv
package vm_pkg;

  typedef enum logic [1:0] {
    ST_STBY = 2'd0,
    ST_IDLE = 2'd1,
    ST_REC  = 2'd2,
    ST_PLAY = 2'd3
  } vm_state_e;

  // number of addresses in one slot when 2**lg slots share 2**aw words
  function automatic int slot_span(int aw, int lg);
    return 1 << (aw - lg);
  endfunction

  // first address of slot k
  function automatic int slot_base(int aw, int lg, int k);
    return k << (aw - lg);
  endfunction

endpackage

// File: rtl/vm_key_filter.sv
module vm_key_filter #(
  parameter int DEB_CYC = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic hold,
  input  logic raw_n,
  output logic level_n,
  output logic press
);
  localparam int CW = $clog2(DEB_CYC + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      s1 <= 1'b1; s2 <= 1'b1; level_n <= 1'b1; cnt <= '0; press <= 1'b0;
    end else if (hold) begin
      s1 <= 1'b1; s2 <= 1'b1; level_n <= 1'b1; cnt <= '0; press <= 1'b0;
    end else begin
      s1    <= raw_n;
      s2    <= s1;
      press <= 1'b0;
      if (s2 != level_n) begin
        if (cnt == CW'(DEB_CYC - 1)) begin
          level_n <= s2;
          cnt     <= '0;
          press   <= ~s2;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/vm_slot_dir.sv
module vm_slot_dir #(
  parameter int LW = 17,
  parameter int NK = 8
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  purge,
  input  logic [1:0]            cur_lg,
  input  logic                  drop_en,
  input  logic [$clog2(NK)-1:0] drop_idx,
  input  logic                  set_en,
  input  logic [$clog2(NK)-1:0] set_idx,
  input  logic [LW-1:0]         set_len,
  input  logic [$clog2(NK)-1:0] look_idx,
  output logic [LW-1:0]         look_len,
  output logic                  look_ok
);
  logic [LW-1:0] len_q [NK];
  logic [1:0]    tag_q [NK];
  logic [NK-1:0] vld_q;

  generate
    for (genvar k = 0; k < NK; k++) begin : g_slot
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
          len_q[k] <= '0; tag_q[k] <= '0; vld_q[k] <= 1'b0;
        end else if (purge) begin
          if (tag_q[k] != cur_lg) vld_q[k] <= 1'b0;
        end else if (set_en && set_idx == k) begin
          len_q[k] <= set_len; tag_q[k] <= cur_lg; vld_q[k] <= 1'b1;
        end else if (drop_en && drop_idx == k) begin
          vld_q[k] <= 1'b0;
        end
      end
    end
  endgenerate

  assign look_len = len_q[look_idx];
  assign look_ok  = vld_q[look_idx] && (tag_q[look_idx] == cur_lg) && (len_q[look_idx] != '0);

endmodule

// File: rtl/voice_msg_ctrl.sv
module voice_msg_ctrl
  import vm_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DEB_CYC = 16000
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [1:0]        msel,
  input  logic              rec_n,
  input  logic [7:0]        key_n,
  input  logic              tick,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic              beep_once,
  output logic              beep_twice,
  output logic              busy_n
);
  localparam int NK = 8;
  localparam int SW = $clog2(NK);
  localparam int LW = ADDR_W + 1;

  vm_state_e     state;
  logic [1:0]    lg_q;
  logic [SW-1:0] cur_q;
  logic [LW-1:0] off_q, plen_q;
  logic          rec_s1, rec_s2;

  // key filters, one per key
  logic [NK-1:0] level_n, press;
  generate
    for (genvar k = 0; k < NK; k++) begin : g_key
      vm_key_filter #(.DEB_CYC(DEB_CYC)) u_filt (
        .clk(clk), .por_n(por_n), .hold(!rst_n),
        .raw_n(key_n[k]), .level_n(level_n[k]), .press(press[k])
      );
    end
  endgenerate

  // keys beyond the latched slot count are masked
  logic [NK-1:0] hit;
  logic [SW-1:0] hit_idx;
  always_comb begin
    hit_idx = '0;
    for (int k = 0; k < NK; k++) hit[k] = press[k] && ((SW'(k) >> lg_q) == '0);
    for (int k = NK - 1; k >= 0; k--) if (hit[k]) hit_idx = SW'(k);
  end

  logic [LW-1:0]     look_len;
  logic              look_ok;
  logic [LW-1:0]     span_w;
  logic [ADDR_W-1:0] base_w, addr_w;
  assign span_w = LW'(slot_span(ADDR_W, int'(lg_q)));
  assign base_w = ADDR_W'(slot_base(ADDR_W, int'(lg_q), int'(cur_q)));
  assign addr_w = base_w + off_q[ADDR_W-1:0];

  // named events
  logic wake, start_rec, start_play, rec_tick, end_rec, play_tick, end_play;
  logic in_rec, in_play;
  assign in_rec     = (state == ST_REC);
  assign in_play    = (state == ST_PLAY);
  assign wake       = (state == ST_STBY) && rst_n;
  assign start_rec  = (state == ST_IDLE) && rst_n && !rec_s2 && (|hit);
  assign start_play = (state == ST_IDLE) && rst_n && rec_s2 && (|hit) && look_ok;
  assign rec_tick   = in_rec && tick;
  assign end_rec    = in_rec && ((rec_tick && off_q == span_w - 1'b1) || level_n[cur_q]);
  assign play_tick  = in_play && tick;
  assign end_play   = in_play && (press[cur_q] || (play_tick && off_q + 1'b1 == plen_q));

  vm_slot_dir #(.LW(LW), .NK(NK)) u_dir (
    .clk(clk), .por_n(por_n), .purge(wake), .cur_lg(lg_q),
    .drop_en(start_rec), .drop_idx(hit_idx),
    .set_en(end_rec && rst_n), .set_idx(cur_q), .set_len(off_q + LW'(rec_tick)),
    .look_idx(hit_idx), .look_len(look_len), .look_ok(look_ok)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state <= ST_STBY; lg_q <= 2'd3; cur_q <= '0; off_q <= '0; plen_q <= '0;
      rec_s1 <= 1'b1; rec_s2 <= 1'b1; mem_addr <= '0;
      mem_wr <= 1'b0; mem_rd <= 1'b0; beep_once <= 1'b0; beep_twice <= 1'b0;
    end else begin
      rec_s1     <= rec_n;
      rec_s2     <= rec_s1;
      mem_wr     <= 1'b0;
      mem_rd     <= 1'b0;
      beep_once  <= 1'b0;
      beep_twice <= 1'b0;
      if (!rst_n) begin
        state <= ST_STBY;
        lg_q  <= msel;
      end else begin
        unique case (state)
          ST_STBY: begin
            beep_once <= 1'b1;
            state     <= ST_IDLE;
          end
          ST_IDLE: begin
            if (start_rec) begin
              beep_once <= 1'b1;
              cur_q     <= hit_idx;
              off_q     <= '0;
              state     <= ST_REC;
            end else if (start_play) begin
              cur_q  <= hit_idx;
              off_q  <= '0;
              plen_q <= look_len;
              state  <= ST_PLAY;
            end
          end
          ST_REC: begin
            if (rec_tick) begin
              mem_wr   <= 1'b1;
              mem_addr <= addr_w;
              off_q    <= off_q + 1'b1;
            end
            if (end_rec) begin
              beep_twice <= 1'b1;
              state      <= ST_IDLE;
            end
          end
          ST_PLAY: begin
            if (play_tick && !press[cur_q]) begin
              mem_rd   <= 1'b1;
              mem_addr <= addr_w;
              off_q    <= off_q + 1'b1;
            end
            if (end_play) state <= ST_IDLE;
          end
          default: state <= ST_STBY;
        endcase
      end
    end
  end

  assign busy_n = !(in_rec || in_play);

endmodule

// File: rtl/vm_ctrl_chk.sv
module vm_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_wr,
  input logic              mem_rd,
  input logic              beep_once,
  input logic              beep_twice,
  input logic              busy_n,
  input logic [1:0]        lg_q,
  input logic [2:0]        cur_slot,
  input logic              in_rec,
  input logic              in_play
);

  a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!por_n)
    $past(rst_n) |-> $stable(lg_q));

  a_r2_addr_in_slot: assert property (@(posedge clk) disable iff (!por_n)
    (mem_wr || mem_rd) |-> ((32'(mem_addr) >> (ADDR_W - int'(lg_q))) == 32'(cur_slot)));

  a_r3_wr_after_rec: assert property (@(posedge clk) disable iff (!por_n)
    mem_wr |-> $past(in_rec));

  a_r6_rd_after_play: assert property (@(posedge clk) disable iff (!por_n)
    mem_rd |-> $past(in_play));

  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({mem_wr, mem_rd}));

  a_r8_strobe_busy: assert property (@(posedge clk) disable iff (!por_n)
    (mem_wr || mem_rd) |-> $past(!busy_n));

  a_r4_double_beep_pulse: assert property (@(posedge clk) disable iff (!por_n)
    beep_twice |=> !beep_twice);

  a_r9_standby_quiet: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> (busy_n && !mem_wr && !mem_rd));

  a_r9_wake_beep: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n) |=> beep_once);

endmodule

bind voice_msg_ctrl vm_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .mem_addr(mem_addr),
  .mem_wr(mem_wr), .mem_rd(mem_rd), .beep_once(beep_once), .beep_twice(beep_twice),
  .busy_n(busy_n), .lg_q(lg_q), .cur_slot(cur_q), .in_rec(in_rec), .in_play(in_play)
);

// File: tb/tb_voice_msg_ctrl.sv
module tb_voice_msg_ctrl;
  localparam int CLK_P   = 10;
  localparam int AW      = 6;
  localparam int DEB     = 4;
  localparam int MEMSZ   = 1 << AW;

  logic          clk, por_n, rst_n, rec_n, tick;
  logic [1:0]    msel;
  logic [7:0]    key_n;
  logic [AW-1:0] mem_addr;
  logic          mem_wr, mem_rd, beep_once, beep_twice, busy_n;

  voice_msg_ctrl #(.ADDR_W(AW), .DEB_CYC(DEB)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .msel(msel), .rec_n(rec_n),
    .key_n(key_n), .tick(tick), .mem_addr(mem_addr), .mem_wr(mem_wr),
    .mem_rd(mem_rd), .beep_once(beep_once), .beep_twice(beep_twice), .busy_n(busy_n)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int wr_cnt = 0, rd_cnt = 0, b1_cnt = 0, b2_cnt = 0, first_a = -1, last_a = -1;

  initial begin
    clk = 1'b0;
    forever #(CLK_P / 2) clk = ~clk;
  end

  // monitor: sees values settled in the previous cycle
  always @(posedge clk) begin
    if (mem_wr || mem_rd) begin
      if (wr_cnt + rd_cnt == 0) first_a = int'(mem_addr);
      last_a = int'(mem_addr);
    end
    if (mem_wr) wr_cnt++;
    if (mem_rd) rd_cnt++;
    if (beep_once) b1_cnt++;
    if (beep_twice) b2_cnt++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    wr_cnt = 0; rd_cnt = 0; first_a = -1; last_a = -1;
  endtask

  task automatic wake(input logic [1:0] m);
    int b;
    rst_n = 1'b0; msel = m; cyc(4);
    b = b1_cnt;
    rst_n = 1'b1; cyc(4);
    chk(b1_cnt == b + 1, "R9 wake single beep", b1_cnt - b, 1);
    chk(busy_n == 1'b1, "R9 idle after wake", int'(busy_n), 1);
  endtask

  task automatic tap(input int k, input int hold_c);
    key_n[k] = 1'b0; cyc(hold_c); key_n[k] = 1'b1;
  endtask

  initial begin
    por_n = 1'b0; rst_n = 1'b0; msel = 2'd3; rec_n = 1'b1; key_n = 8'hFF; tick = 1'b0;
    cyc(3);
    chk(busy_n == 1'b1, "R8 reset busy high", int'(busy_n), 1);
    chk(!mem_wr && !mem_rd, "R8 reset no strobe", int'(mem_wr) + int'(mem_rd), 0);
    por_n = 1'b1; cyc(2);

    // sweep all modes and keys
    for (int m = 0; m < 4; m++) begin
      int nsl, span;
      nsl  = 1 << m;
      span = MEMSZ / nsl;
      wake(2'(m));
      rec_n = 1'b0; tick = 1'b1; cyc(4);
      for (int k = 0; k < 8; k++) begin
        int b1, b2;
        clr_mon(); b1 = b1_cnt; b2 = b2_cnt;
        tap(k, span + 30); cyc(15);
        if (k < nsl) begin
          chk(wr_cnt == span, "R4 full slot write count", wr_cnt, span);
          chk(first_a == k * span, "R1 R2 slot base", first_a, k * span);
          chk(last_a == k * span + span - 1, "R2 slot last address", last_a, k * span + span - 1);
          chk(b1_cnt == b1 + 1, "R3 start beep", b1_cnt - b1, 1);
          chk(b2_cnt == b2 + 1, "R4 finish double beep", b2_cnt - b2, 1);
        end else begin
          chk(wr_cnt == 0, "R2 masked key no write", wr_cnt, 0);
          chk(b1_cnt == b1, "R2 masked key no beep", b1_cnt - b1, 0);
        end
        chk(busy_n == 1'b1, "R8 idle after record", int'(busy_n), 1);
      end
      rec_n = 1'b1; cyc(4);
      for (int k = 0; k < 8; k++) begin
        int exp_n;
        exp_n = (k < nsl) ? span : 0;
        clr_mon();
        tap(k, 10); cyc(span + 20);
        chk(rd_cnt == exp_n, "R6 R7 playback read count", rd_cnt, exp_n);
        if (k < nsl) chk(first_a == k * span, "R6 playback base", first_a, k * span);
        chk(busy_n == 1'b1, "R7 idle at message end", int'(busy_n), 1);
      end
      tick = 1'b0;
    end

    // short record replaces a full slot (mode 3, slot 1, span 8)
    rec_n = 1'b0; cyc(4); clr_mon();
    key_n[1] = 1'b0; cyc(12);
    chk(busy_n == 1'b0, "R8 busy while recording", int'(busy_n), 0);
    tick = 1'b1; cyc(5); tick = 1'b0;
    key_n[1] = 1'b1; cyc(15);
    chk(wr_cnt == 5, "R4 release stops record", wr_cnt, 5);
    chk(first_a == 8, "R3 record from slot base", first_a, 8);
    rec_n = 1'b1; tick = 1'b1; cyc(4); clr_mon();
    tap(1, 10); cyc(30);
    chk(rd_cnt == 5, "R5 replaced length played", rd_cnt, 5);
    tick = 1'b0;

    // bounce shorter than the filter window (slot 1 holds 5)
    clr_mon();
    key_n[1] = 1'b0; cyc(2); key_n[1] = 1'b1; cyc(20);
    chk(busy_n == 1'b1, "R10 short glitch rejected", int'(busy_n), 1);
    tick = 1'b1; cyc(10); tick = 1'b0;
    chk(rd_cnt == 0, "R10 glitch gives no read", rd_cnt, 0);

    // empty slot in play position (slot 7 in mode 3 was played-only? recorded full; use discarded later)
    // standby in the middle of a recording (slot 3)
    rec_n = 1'b0; cyc(4); clr_mon();
    key_n[3] = 1'b0; cyc(12);
    chk(busy_n == 1'b0, "R3 recording started", int'(busy_n), 0);
    rst_n = 1'b0; cyc(2);
    chk(busy_n == 1'b1, "R9 standby clears busy", int'(busy_n), 1);
    tick = 1'b1; cyc(5);
    chk(wr_cnt == 0, "R9 no write in standby", wr_cnt, 0);
    key_n = 8'hFF; cyc(2);
    tap(4, 12); cyc(4);
    chk(busy_n == 1'b1, "R9 press ignored in standby", int'(busy_n), 1);
    tick = 1'b0;
    begin
      int b;
      b = b1_cnt;
      rst_n = 1'b1; cyc(4);
      chk(b1_cnt == b + 1, "R9 wake beep", b1_cnt - b, 1);
    end
    rec_n = 1'b1; tick = 1'b1; cyc(4); clr_mon();
    tap(3, 10); cyc(30);
    chk(rd_cnt == 0, "R5 abandoned record leaves slot empty", rd_cnt, 0);
    chk(busy_n == 1'b1, "R12 empty slot no busy", int'(busy_n), 1);
    tick = 1'b0;

    // stop on second press (mode 0, span 64)
    wake(2'd0);
    rec_n = 1'b0; tick = 1'b1; cyc(4);
    tap(0, 100); cyc(15); tick = 1'b0;
    rec_n = 1'b1; cyc(4); clr_mon();
    key_n[0] = 1'b0; cyc(12);
    chk(busy_n == 1'b0, "R6 playback busy", int'(busy_n), 0);
    key_n[0] = 1'b1; cyc(12);
    tick = 1'b1; cyc(10); tick = 1'b0;
    tap(0, 10); cyc(10);
    chk(busy_n == 1'b1, "R7 second press stops", int'(busy_n), 1);
    chk(rd_cnt == 10, "R7 reads before stop", rd_cnt, 10);

    // mode change discards slots, also when going back
    wake(2'd3);
    tick = 1'b1; clr_mon();
    tap(0, 10); cyc(80);
    chk(rd_cnt == 0, "R11 other mode slot empty", rd_cnt, 0);
    chk(busy_n == 1'b1, "R11 no busy on discarded slot", int'(busy_n), 1);
    tick = 1'b0;
    wake(2'd0);
    tick = 1'b1; clr_mon();
    tap(0, 10); cyc(80);
    chk(rd_cnt == 0, "R11 discard persists after mode returns", rd_cnt, 0);
    tick = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule